// File: doc/BRIEF.md
# Tile Depth Occlusion Tester

This block answers conservative visibility queries at screen-tile resolution. The screen is divided into a fixed number of equal tiles. For each tile the block keeps one depth value, which is the farthest depth known to be covered there. A query gives a tile index and the nearest depth a triangle reaches inside that tile. The block reports whether the triangle is certainly behind everything already drawn in the tile. If it is, every pixel of that chunk can be skipped. The test is conservative, so a triangle is never wrongly hidden. The same unit can sit in front of a long primitive queue and again after it.

The pixel pipeline feeds tile results back through an update port. An update can only pull a tile's stored depth closer. Updates are refused when the primitive's depth writes are not final, for example when alpha or stencil rejection is active or when the shader alters depth. Storage has two banks. The bank being tested and the bank being written are selected separately, and the selection is latched on a frame marker. This lets one frame drain while the next frame builds its occlusion data. A clear resets every tile of one bank to the farthest depth code.

Top module: `tile_occl_top`

## Requirements
- R1: After reset, every tile of both banks holds the farthest depth code (all ones), both bank selects read 0, and no result is valid.
- R2: Smaller depth codes are closer. A query is reported hidden only when its nearest depth is strictly greater than the tile's stored depth. Equal or smaller depths are reported visible.
- R3: Each query produces `res_valid` exactly one cycle after `qry_valid`. `res_hidden` is 0 whenever `res_valid` is 0.
- R4: An accepted update sets the tile to the smaller of its stored value and `upd_maxz`. A stored value never increases except through a clear.
- R5: An update with `upd_final` low changes no stored depth.
- R6: A clear sets every tile of the bank named by `clr_bank` to all ones. An accepted update to that bank in the same cycle is applied on top of the cleared value.
- R7: `test_bank` and `upd_bank` load `nxt_test_bank` and `nxt_upd_bank` on a cycle with `frame_mark` high. The new selection is used from the next cycle on. At all other times both selects hold.
- R8: Updates and clears touch only their own bank. Queries read only the bank shown on `test_bank`.
- R9: A query sees the effect of a clear or accepted update made to the tested bank in the same cycle, including one to the same tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mark | input | 1 | Frame marker pulse; latches the bank selects |
| nxt_test_bank | input | 1 | Bank to test after the next frame marker |
| nxt_upd_bank | input | 1 | Bank to update after the next frame marker |
| clr_valid | input | 1 | Clear the bank named by clr_bank |
| clr_bank | input | 1 | Bank to clear |
| upd_valid | input | 1 | Tile depth update request |
| upd_final | input | 1 | Depth writes of the primitive are final; update allowed |
| upd_tile | input | 6 | Tile index of the update |
| upd_maxz | input | 16 | Farthest depth now covering the tile |
| qry_valid | input | 1 | Occlusion query request |
| qry_tile | input | 6 | Tile index of the query |
| qry_minz | input | 16 | Nearest triangle depth within the tile |
| res_valid | output | 1 | Query result strobe |
| res_hidden | output | 1 | Triangle chunk is hidden |
| test_bank | output | 1 | Bank currently used by queries |
| upd_bank | output | 1 | Bank currently used by updates |

## Verification
A query result appears on the first clock edge after the query is presented. A change to the bank selects likewise becomes visible one edge after the frame marker. Updates and clears change stored depth at that same edge, so they first influence a query in the next cycle. The exception is a query in the same cycle, which sees them through forwarding. The bench drives inputs on the falling edge and runs its reference model on the stimulus for that cycle. After the next rising edge it compares every output at the falling edge. Directed checks on hand-computed values are sampled at the same point.

// File: rtl/tile_occl_pkg.sv
package tile_occl_pkg;
  parameter int unsigned ZW = 16;
  typedef logic [ZW-1:0] depth_t;
  localparam depth_t DEPTH_FAR = '1;

  // conservative test: hidden only when strictly behind the tile's far depth
  function automatic logic tile_hidden(input depth_t tri_near, input depth_t tile_far);
    return tri_near > tile_far;
  endfunction

  function automatic depth_t depth_lower(input depth_t a, input depth_t b);
    return (b < a) ? b : a;
  endfunction
endpackage

// File: rtl/tile_depth_bank.sv
module tile_depth_bank
  import tile_occl_pkg::*;
#(
  parameter int TILES = 64,
  localparam int IDX_W = $clog2(TILES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_tile,
  input  depth_t           upd_z,
  input  logic [IDX_W-1:0] rd_tile,
  output depth_t           rd_eff
);
  depth_t mem [TILES];
  depth_t nxt [TILES];

  always_comb begin
    for (int i = 0; i < TILES; i++) begin
      depth_t base;
      base = clr ? DEPTH_FAR : mem[i];
      nxt[i] = (upd_en && upd_tile == IDX_W'(i)) ? depth_lower(base, upd_z) : base;
    end
  end

  // forwarded view: includes this cycle's clear and update
  assign rd_eff = nxt[rd_tile];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TILES; i++) mem[i] <= DEPTH_FAR;
    end else begin
      for (int i = 0; i < TILES; i++) mem[i] <= nxt[i];
    end
  end

  // observation registers for the assertions
  logic             chk_arm;
  logic             chk_clr;
  logic [IDX_W-1:0] chk_tile;
  depth_t           chk_old;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_arm  <= 1'b0;
      chk_clr  <= 1'b0;
      chk_tile <= '0;
      chk_old  <= '0;
    end else begin
      chk_arm  <= upd_en && !clr;
      chk_clr  <= clr && !upd_en;
      chk_tile <= upd_tile;
      chk_old  <= mem[upd_tile];
    end
  end

  AST_NEVER_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm |-> (mem[chk_tile] <= chk_old)); // R4
  AST_CLEAR_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    chk_clr |-> (mem[0] == DEPTH_FAR && mem[TILES-1] == DEPTH_FAR)); // R6
endmodule

// File: rtl/tile_occl_bank_ctl.sv
module tile_occl_bank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_mark,
  input  logic nxt_test_bank,
  input  logic nxt_upd_bank,
  output logic test_bank,
  output logic upd_bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_bank <= 1'b0;
      upd_bank  <= 1'b0;
    end else if (frame_mark) begin
      test_bank <= nxt_test_bank;
      upd_bank  <= nxt_upd_bank;
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_mark |=> ($stable(test_bank) && $stable(upd_bank))); // R7
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> (test_bank == $past(nxt_test_bank) && upd_bank == $past(nxt_upd_bank))); // R7
endmodule

// File: rtl/tile_occl_result.sv
module tile_occl_result
  import tile_occl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   qry_valid,
  input  depth_t qry_minz,
  input  depth_t tile_z,
  output logic   res_valid,
  output logic   res_hidden
);
  logic hide_now;
  assign hide_now = tile_hidden(qry_minz, tile_z);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hidden <= 1'b0;
    end else begin
      res_valid  <= qry_valid;
      res_hidden <= qry_valid && hide_now;
    end
  end

  AST_RES_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> res_valid); // R3
  AST_RES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> !res_valid); // R3
  AST_NO_STRAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_hidden); // R3
  AST_EQUAL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_minz <= tile_z) |=> !res_hidden); // R2
endmodule

// File: rtl/tile_occl_top.sv
module tile_occl_top
  import tile_occl_pkg::*;
#(
  parameter int TILES = 64,
  parameter int DEPTH_W = tile_occl_pkg::ZW,
  localparam int IDX_W = $clog2(TILES),
  localparam int BANKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_mark,
  input  logic               nxt_test_bank,
  input  logic               nxt_upd_bank,
  input  logic               clr_valid,
  input  logic               clr_bank,
  input  logic               upd_valid,
  input  logic               upd_final,
  input  logic [IDX_W-1:0]   upd_tile,
  input  logic [DEPTH_W-1:0] upd_maxz,
  input  logic               qry_valid,
  input  logic [IDX_W-1:0]   qry_tile,
  input  logic [DEPTH_W-1:0] qry_minz,
  output logic               res_valid,
  output logic               res_hidden,
  output logic               test_bank,
  output logic               upd_bank
);
  logic   upd_accept;
  depth_t bank_eff [BANKS];
  logic   bank_upd [BANKS];
  logic   bank_clr [BANKS];

  assign upd_accept = upd_valid && upd_final;

  tile_occl_bank_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .frame_mark(frame_mark),
    .nxt_test_bank(nxt_test_bank), .nxt_upd_bank(nxt_upd_bank),
    .test_bank(test_bank), .upd_bank(upd_bank)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_upd[b] = upd_accept && (upd_bank == 1'(b));
    assign bank_clr[b] = clr_valid && (clr_bank == 1'(b));
    tile_depth_bank #(.TILES(TILES)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(bank_clr[b]), .upd_en(bank_upd[b]),
      .upd_tile(upd_tile), .upd_z(upd_maxz), .rd_tile(qry_tile), .rd_eff(bank_eff[b])
    );
  end

  tile_occl_result u_res (
    .clk(clk), .rst_n(rst_n), .qry_valid(qry_valid), .qry_minz(qry_minz),
    .tile_z(bank_eff[test_bank]), .res_valid(res_valid), .res_hidden(res_hidden)
  );

  AST_REFUSE_NONFINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_final) |-> !(bank_upd[0] || bank_upd[1])); // R5
  AST_ONE_BANK_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_upd[0] && bank_upd[1])); // R8
endmodule

// File: tb/tile_occl_top_tb.sv
module tile_occl_top_tb;
  localparam int TILES = 64;
  localparam int FAR = 65535;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_mark, nxt_test_bank, nxt_upd_bank, clr_valid, clr_bank;
  logic upd_valid, upd_final, qry_valid;
  logic [5:0] upd_tile, qry_tile;
  logic [15:0] upd_maxz, qry_minz;
  logic res_valid, res_hidden, test_bank, upd_bank;

  int vectors = 0, errors = 0;
  int ref_mem [2][TILES];
  int ref_tb = 0, ref_ub = 0;
  int exp_rv = 0, exp_rh = 0;

  always #2 clk = ~clk;

  tile_occl_top u_dut (
    .clk(clk), .rst_n(rst_n), .frame_mark(frame_mark), .nxt_test_bank(nxt_test_bank),
    .nxt_upd_bank(nxt_upd_bank), .clr_valid(clr_valid), .clr_bank(clr_bank),
    .upd_valid(upd_valid), .upd_final(upd_final), .upd_tile(upd_tile), .upd_maxz(upd_maxz),
    .qry_valid(qry_valid), .qry_tile(qry_tile), .qry_minz(qry_minz),
    .res_valid(res_valid), .res_hidden(res_hidden), .test_bank(test_bank), .upd_bank(upd_bank)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    frame_mark = 0; nxt_test_bank = 0; nxt_upd_bank = 0; clr_valid = 0; clr_bank = 0;
    upd_valid = 0; upd_final = 0; upd_tile = 0; upd_maxz = 0;
    qry_valid = 0; qry_tile = 0; qry_minz = 0;
  endtask

  // reference model for one clock, then compare at the falling edge
  task automatic cycle();
    int eff [2][TILES];
    for (int b = 0; b < 2; b++)
      for (int t = 0; t < TILES; t++) begin
        eff[b][t] = (clr_valid && clr_bank == b) ? FAR : ref_mem[b][t];
        if (upd_valid && upd_final && ref_ub == b && upd_tile == t && upd_maxz < eff[b][t])
          eff[b][t] = upd_maxz;
      end
    exp_rv = qry_valid;
    exp_rh = (qry_valid && qry_minz > eff[ref_tb][qry_tile]) ? 1 : 0;
    ref_mem = eff;
    if (frame_mark) begin ref_tb = nxt_test_bank; ref_ub = nxt_upd_bank; end
    @(posedge clk);
    @(negedge clk);
    chk("R3 res_valid", res_valid, exp_rv);
    chk("R2 res_hidden", res_hidden, exp_rh);
    chk("R7 test_bank", test_bank, ref_tb);
    chk("R7 upd_bank", upd_bank, ref_ub);
    idle();
  endtask

  task automatic upd(input int t, input int z, input bit fin);
    upd_valid = 1; upd_final = fin; upd_tile = 6'(t); upd_maxz = 16'(z);
  endtask

  task automatic qry(input int t, input int z);
    qry_valid = 1; qry_tile = 6'(t); qry_minz = 16'(z);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int t = 0; t < TILES; t++) ref_mem[b][t] = FAR;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 res_valid", res_valid, 0);
    chk("R1 test_bank", test_bank, 0);
    chk("R1 upd_bank", upd_bank, 0);
    qry(5, FAR); cycle(); chk("R1 far equal visible", res_hidden, 0);

    upd(3, 100, 1); cycle();
    qry(3, 101); cycle(); chk("R2 behind hidden", res_hidden, 1);
    qry(3, 100); cycle(); chk("R2 equal visible", res_hidden, 0);
    qry(3, 99);  cycle(); chk("R2 closer visible", res_hidden, 0);
    cycle(); chk("R3 no result", res_valid, 0);
    upd(3, 200, 1); cycle();
    qry(3, 101); cycle(); chk("R4 never raised", res_hidden, 1);
    upd(3, 50, 0); cycle();
    qry(3, 60); cycle(); chk("R5 nonfinal ignored", res_hidden, 0);
    upd(3, 40, 1); qry(3, 45); cycle(); chk("R9 same-cycle forward", res_hidden, 1);

    frame_mark = 1; nxt_test_bank = 0; nxt_upd_bank = 1; cycle();
    chk("R7 upd bank swapped", upd_bank, 1);
    upd(7, 10, 1); cycle();
    qry(7, 20); cycle(); chk("R8 other bank untouched", res_hidden, 0);
    nxt_test_bank = 1; nxt_upd_bank = 1; cycle();
    qry(7, 20); cycle(); chk("R7 no swap without marker", res_hidden, 0);
    frame_mark = 1; nxt_test_bank = 1; nxt_upd_bank = 1; cycle();
    qry(7, 20); cycle(); chk("R8 test bank one", res_hidden, 1);
    clr_valid = 1; clr_bank = 1; qry(7, 20); cycle(); chk("R9 clear forwarded", res_hidden, 0);
    qry(7, 20); cycle(); chk("R6 cleared", res_hidden, 0);
    frame_mark = 1; nxt_test_bank = 0; nxt_upd_bank = 0; cycle();
    qry(3, 45); cycle(); chk("R8 clear kept to bank one", res_hidden, 1);
    clr_valid = 1; clr_bank = 0; upd(3, 500, 1); cycle();
    qry(3, 501); cycle(); chk("R6 update over clear", res_hidden, 1);
    qry(4, 501); cycle(); chk("R6 other tile cleared", res_hidden, 0);

    for (int n = 0; n < 4000; n++) begin
      frame_mark = ($urandom_range(0, 15) == 0);
      nxt_test_bank = $urandom_range(0, 1);
      nxt_upd_bank = $urandom_range(0, 1);
      clr_valid = ($urandom_range(0, 63) == 0);
      clr_bank = $urandom_range(0, 1);
      if ($urandom_range(0, 1) == 1) upd($urandom_range(0, 7), $urandom_range(0, 400), $urandom_range(0, 3) != 0);
      if ($urandom_range(0, 3) != 0) qry($urandom_range(0, 7), $urandom_range(0, 450));
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule